// File: doc/BRIEF.md
# Shadow State Swap Test Sequencer

This block keeps a small bank of live processor state and a shadow bank of the same size. Software reaches the shadow bank one 64-bit word at a time. It writes a word from its data register into any shadow word, or it reads a shadow word back into the read register. Live state never passes through this port.

To test the logic that drives the live state, software first loads a stimulus pattern into the shadow bank and then issues a test command. The block then runs a fixed, uninterruptible three-cycle sequence:

1. The two banks trade their whole contents.
2. The logic under test takes exactly one functional step.
3. The banks trade contents again.

At the end the live state is back to what it held before the command, and the shadow bank holds the response. Software reads the response out and compares it against its own expected values.

Outside a test, the live state advances through the same next-state function whenever the functional clock enable is high. That function is a small, parameterised stand-in for real logic.

Top module: `shadow_swap_seq`

## Requirements
- R1: After reset, busy, done and rd_data are 0, every shadow word is 0, and live word i holds the value i+1.
- R2: When the block is idle and wr_en is high, shadow word word_idx takes wr_data at the clock edge. This includes the cycle in which a test command is accepted. If word_idx is NUM_WORDS or more, the write is dropped.
- R3: When the block is idle and rd_en is high, rd_data takes shadow word word_idx (its value before any write in the same cycle) at the clock edge, or 0 if word_idx is NUM_WORDS or more. Otherwise rd_data keeps its value.
- R4: A test command taken while idle makes busy high for exactly the next three cycles. done is high for exactly one cycle, the cycle just after busy falls. A test command while busy has no effect.
- R5: In the first and third cycles of a test, the whole live bank and the whole shadow bank exchange contents. After the test, every live word equals its value from before the test.
- R6: After a test, shadow word i equals F(P)[i], where P is the pattern held in the shadow bank when the test started. F(P)[i] = rotate-left-by-one(P[i]) XOR P[(i+1) mod NUM_WORDS] XOR (i+1).
- R7: While busy, word writes and reads are refused: the shadow bank is not changed by wr_en and rd_data holds its value.
- R8: While idle with run_en high, the live bank steps to F(live) at the clock edge. run_en has no effect while busy.
- R9: live_peek shows, in the same cycle, live word word_idx, or 0 if word_idx is NUM_WORDS or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_idx | input | IDX_W | Word index for read, write and peek |
| wr_en | input | 1 | Copy wr_data into a shadow word |
| wr_data | input | WORD_W | Architectural data register value |
| rd_en | input | 1 | Copy a shadow word into rd_data |
| rd_data | output | WORD_W | Read register |
| test_start | input | 1 | Start the three-cycle test |
| run_en | input | 1 | Functional step enable for the live bank |
| busy | output | 1 | Test sequence in progress |
| done | output | 1 | One-cycle pulse after the test ends |
| live_peek | output | WORD_W | Selected live word |

## Verification
A corrupted live word appears on live_peek in the same cycle the index selects it. A wrong swap or a missed restore therefore shows one cycle after busy falls. A corrupted shadow word appears on rd_data one cycle after it is read. A phase counter that skips or sticks shows at once as a busy or done mismatch. The reference model tracks both banks and the phase, and it is compared on every clock, so each such error is caught within one or two cycles of the first visible difference.

// File: rtl/ssq_pkg.sv
package ssq_pkg;
   typedef enum logic [1:0] {
      PH_IDLE     = 2'd0,
      PH_SWAP_IN  = 2'd1,
      PH_TICK     = 2'd2,
      PH_SWAP_OUT = 2'd3
   } ssq_phase_e;
endpackage

// File: rtl/ssq_ctrl.sv
module ssq_ctrl
   import ssq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       test_start,
   output ssq_phase_e phase,
   output logic       busy,
   output logic       done
);
   ssq_phase_e state_q;
   logic       done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= PH_IDLE;
         done_q  <= 1'b0;
      end else begin
         done_q <= (state_q == PH_SWAP_OUT);
         case (state_q)
            PH_IDLE:     if (test_start) state_q <= PH_SWAP_IN;
            PH_SWAP_IN:  state_q <= PH_TICK;
            PH_TICK:     state_q <= PH_SWAP_OUT;
            default:     state_q <= PH_IDLE;
         endcase
      end
   end

   assign phase = state_q;
   assign busy  = (state_q != PH_IDLE);
   assign done  = done_q;

   AST_START_TAKES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && test_start) |=> busy); // R4
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R4
   AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done); // R4
   AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PH_SWAP_OUT) |=> (state_q == PH_IDLE)); // R4
endmodule

// File: rtl/ssq_next_state.sv
module ssq_next_state #(
   parameter int WORD_W    = 64,
   parameter int NUM_WORDS = 5,
   parameter int NS_KIND   = 0
) (
   input  logic [NUM_WORDS-1:0][WORD_W-1:0] cur_i,
   output logic [NUM_WORDS-1:0][WORD_W-1:0] nxt_o
);
   for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
      localparam int NB = (i + 1) % NUM_WORDS;
      if (NS_KIND == 0) begin : g_rotx
         assign nxt_o[i] = {cur_i[i][WORD_W-2:0], cur_i[i][WORD_W-1]}
                           ^ cur_i[NB] ^ WORD_W'(i + 1);
      end else begin : g_addn
         assign nxt_o[i] = cur_i[i] + cur_i[NB] + WORD_W'(i + 1);
      end
   end
endmodule

// File: rtl/shadow_swap_seq.sv
module shadow_swap_seq
   import ssq_pkg::*;
#(
   parameter int WORD_W    = 64,
   parameter int NUM_WORDS = 5,
   parameter int IDX_W     = 3,
   parameter int NS_KIND   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  word_idx,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [WORD_W-1:0] rd_data,
   input  logic              test_start,
   input  logic              run_en,
   output logic              busy,
   output logic              done,
   output logic [WORD_W-1:0] live_peek
);
   localparam int SEL_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
   localparam logic [IDX_W:0] NW_L = (IDX_W + 1)'(NUM_WORDS);

   if (WORD_W < 2) begin : g_bad_width
      $error("WORD_W must be at least 2");
   end
   if (NUM_WORDS < 2) begin : g_bad_depth
      $error("NUM_WORDS must be at least 2");
   end
   if ((1 << IDX_W) < NUM_WORDS || IDX_W < SEL_W) begin : g_bad_idx
      $error("IDX_W too narrow for NUM_WORDS");
   end
   if (NS_KIND < 0 || NS_KIND > 1) begin : g_bad_kind
      $error("NS_KIND must be 0 or 1");
   end

   ssq_phase_e phase;
   logic       do_swap, do_tick, idle, in_range;
   logic [SEL_W-1:0] sel;
   logic [NUM_WORDS-1:0][WORD_W-1:0] live_q, shadow_q, live_nxt;
   logic [WORD_W-1:0] rd_q;

   ssq_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .test_start (test_start),
      .phase      (phase),
      .busy       (busy),
      .done       (done)
   );

   ssq_next_state #(
      .WORD_W    (WORD_W),
      .NUM_WORDS (NUM_WORDS),
      .NS_KIND   (NS_KIND)
   ) u_ns (
      .cur_i (live_q),
      .nxt_o (live_nxt)
   );

   assign do_swap  = (phase == PH_SWAP_IN) || (phase == PH_SWAP_OUT);
   assign do_tick  = (phase == PH_TICK);
   assign idle     = (phase == PH_IDLE);
   assign in_range = ({1'b0, word_idx} < NW_L);
   assign sel      = word_idx[SEL_W-1:0];

   for (genvar i = 0; i < NUM_WORDS; i++) begin : g_bank
      logic wr_hit;
      assign wr_hit = idle && wr_en && in_range && (sel == SEL_W'(i));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            live_q[i]   <= WORD_W'(i + 1);
            shadow_q[i] <= '0;
         end else if (do_swap) begin
            live_q[i]   <= shadow_q[i];
            shadow_q[i] <= live_q[i];
         end else begin
            if (do_tick || (idle && run_en)) live_q[i] <= live_nxt[i];
            if (wr_hit) shadow_q[i] <= wr_data;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)              rd_q <= '0;
      else if (idle && rd_en)  rd_q <= in_range ? shadow_q[sel] : '0;
   end

   assign rd_data   = rd_q;
   assign live_peek = in_range ? live_q[sel] : '0;

   AST_LIVE_RESTORED: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (live_q == $past(live_q, 3))); // R5
   AST_SHADOW_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (shadow_q == $past(live_q, 1))); // R6
   AST_BUSY_WRITE_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !do_swap) |=> $stable(shadow_q)); // R7
   AST_BUSY_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(rd_data)); // R7
   AST_OOR_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && wr_en && !in_range) |=> $stable(shadow_q)); // R2
   AST_RUN_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_SWAP_OUT) |=> (live_q == $past(shadow_q, 1))); // R8
endmodule

// File: tb/sim_shadow_swap_seq.sv
`timescale 1ns/1ps
module sim_shadow_swap_seq;
   localparam int W = 64;
   localparam int N = 5;
   localparam int IW = 3;

   logic clk = 1'b0;
   logic rst_n;
   logic [IW-1:0] word_idx;
   logic wr_en, rd_en, test_start, run_en;
   logic [W-1:0] wr_data;
   logic [W-1:0] rd_data, live_peek;
   logic busy, done;

   always #4 clk = ~clk;

   shadow_swap_seq #(.WORD_W(W), .NUM_WORDS(N), .IDX_W(IW)) u0 (
      .clk(clk), .rst_n(rst_n), .word_idx(word_idx), .wr_en(wr_en),
      .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
      .test_start(test_start), .run_en(run_en), .busy(busy),
      .done(done), .live_peek(live_peek)
   );

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   logic [W-1:0] live_m [N];
   logic [W-1:0] sh_m   [N];
   logic [W-1:0] tmp_m  [N];
   logic [W-1:0] rd_m;
   int  ph_m;
   logic done_m;
   logic [63:0] rng = 64'h9E3779B97F4A7C15;

   function automatic logic [63:0] nxt_rand();
      rng = rng ^ (rng << 13);
      rng = rng ^ (rng >> 7);
      rng = rng ^ (rng << 17);
      return rng;
   endfunction

   // F from R6 applied to the live model
   function automatic void step_live();
      for (int i = 0; i < N; i++)
         tmp_m[i] = {live_m[i][W-2:0], live_m[i][W-1]} ^ live_m[(i + 1) % N] ^ W'(i + 1);
      for (int i = 0; i < N; i++) live_m[i] = tmp_m[i];
   endfunction

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < N; i++) begin
         live_m[i] = W'(i + 1);
         sh_m[i]   = '0;
      end
      rd_m = '0; ph_m = 0; done_m = 1'b0;
   endtask

   task automatic model_edge();
      logic [W-1:0] t;
      done_m = 1'b0;
      case (ph_m)
         0: begin
            if (rd_en) rd_m = (word_idx < N) ? sh_m[word_idx] : '0;
            if (run_en) step_live();
            if (wr_en && word_idx < N) sh_m[word_idx] = wr_data;
            if (test_start) ph_m = 1;
         end
         1, 3: begin
            for (int i = 0; i < N; i++) begin
               t = live_m[i]; live_m[i] = sh_m[i]; sh_m[i] = t;
            end
            if (ph_m == 3) begin ph_m = 0; done_m = 1'b1; end
            else ph_m = 2;
         end
         default: begin step_live(); ph_m = 3; end
      endcase
   endtask

   // compare all outputs; called away from the active edge
   task automatic compare_all();
      chk("R4 busy", W'(busy), W'(ph_m != 0));
      chk("R4 done", W'(done), W'(done_m));
      chk("R3 rd_data", rd_data, rd_m);
      chk("R9 live_peek", live_peek, (word_idx < N) ? live_m[word_idx] : '0);
   endtask

   task automatic cyc(input logic [IW-1:0] ix, input logic we, input logic [W-1:0] wd,
                      input logic re, input logic st, input logic run);
      word_idx = ix; wr_en = we; wr_data = wd; rd_en = re; test_start = st; run_en = run;
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare_all();
   endtask

   task automatic idle_cyc(input logic [IW-1:0] ix);
      cyc(ix, 1'b0, '0, 1'b0, 1'b0, 1'b0);
   endtask

   initial begin
      rst_n = 1'b0; word_idx = '0; wr_en = 0; wr_data = '0; rd_en = 0;
      test_start = 0; run_en = 0;
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset values of all outputs and of both banks
      chk("R1 busy", W'(busy), '0);
      chk("R1 done", W'(done), '0);
      chk("R1 rd_data", rd_data, '0);
      for (int i = 0; i < N; i++) begin
         idle_cyc(IW'(i));
         chk("R1 live word", live_peek, W'(i + 1));
         cyc(IW'(i), 1'b0, '0, 1'b1, 1'b0, 1'b0);
         idle_cyc(IW'(i));
         chk("R1 shadow word", rd_data, '0);
      end
      // R2: load a pattern, out-of-range write ignored
      for (int i = 0; i < N; i++) cyc(IW'(i), 1'b1, nxt_rand(), 1'b0, 1'b0, 1'b0);
      cyc(IW'(6), 1'b1, 64'hDEAD_BEEF_0000_0001, 1'b0, 1'b0, 1'b0);
      cyc(IW'(6), 1'b0, '0, 1'b1, 1'b0, 1'b0);
      idle_cyc(IW'(6));
      chk("R3 out-of-range read", rd_data, '0);
      // R8: functional stepping of the live bank
      repeat (3) cyc(IW'(2), 1'b0, '0, 1'b0, 1'b0, 1'b1);
      // R4 R5 R6: test run, with restart and run_en attempts while busy
      cyc(IW'(0), 1'b0, '0, 1'b0, 1'b1, 1'b0);
      cyc(IW'(1), 1'b1, 64'h1111, 1'b1, 1'b1, 1'b1); // R7 refused
      cyc(IW'(2), 1'b1, 64'h2222, 1'b1, 1'b1, 1'b1); // R7 refused
      cyc(IW'(3), 1'b1, 64'h3333, 1'b1, 1'b1, 1'b1); // R7 refused
      chk("R4 done after test", W'(done), 64'd1);
      for (int i = 0; i < N; i++) begin
         cyc(IW'(i), 1'b0, '0, 1'b1, 1'b0, 1'b0);
         idle_cyc(IW'(i));
         chk("R6 response word", rd_data, sh_m[i]);
         chk("R5 live restored", live_peek, live_m[i]);
      end
      // R2: write in the start cycle reaches the swap
      cyc(IW'(4), 1'b1, 64'hA5A5_5A5A_0F0F_F0F0, 1'b0, 1'b1, 1'b0);
      repeat (4) idle_cyc(IW'(4));
      // randomised phase, model compared on every clock
      for (int k = 0; k < 800; k++) begin
         logic [63:0] r;
         r = nxt_rand();
         cyc(IW'(r[2:0]), r[3], nxt_rand(), r[4], (r[9:5] == 5'd0), r[10] & r[11]);
      end
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule